// File: doc/BRIEF.md
# Serial Flash Controller with Raw Byte Pipe

This block is a single-bit SPI master placed behind a 32-bit slave port. The port reaches two small registers and a memory-mapped flash window. In the read-translation modes, a bus read of the window turns into a complete flash read frame. The frame carries the read opcode, a 3- or 4-byte address and then the data bytes, and the bytes that come back land in the read data. In write-translation mode, with writes enabled in the configuration register, a window write becomes a program frame in the same way.

Setting the mode field to user mode turns the window into a raw pipe. Each byte written is shifted out on MOSI, and each byte read is shifted in from MISO, with no opcode or address added. Chip select is then held by a separate stop bit. Firmware can therefore frame a multi-access command: it sets stop together with user mode, clears stop, makes the window accesses, sets stop again and finally restores the read-mode control value.

Top module: `spi_flash_ctl`

## Requirements
- R1: After reset, spi_cs_n is 1 and spi_sck and spi_mosi are 0. The control register reads 0x400 (mode 00, stop 0, 3-byte address, gap code 0, divider code 4) and the configuration register reads 0.
- R2: In modes 00, 01 and 10, a window read of n bytes (byte enables 0001, 0011, 0111 or 1111) at byte offset A sends a frame with spi_cs_n low. The frame is opcode 0x03, then A as three bytes most significant first, then n bytes of 0x00. The n bytes received fill read lanes 0 upward in arrival order, and the remaining lanes read 0. Outside a frame, spi_cs_n is high.
- R3: With control bit 3 set, the read frame carries four address bytes, the window offset zero-extended to 32 bits.
- R4: In mode 10, with configuration bit 0 set, a window write sends opcode 0x02, the address, and then the enabled write lanes from lane 0 upward. In modes 00 and 01, or without configuration bit 0, a window write completes with no SCK activity.
- R5: In mode 11, a window write shifts exactly its enabled lanes, lane 0 first. A window read shifts the same number of 0x00 bytes and returns the received bytes in lanes 0 upward. No opcode or address is sent.
- R6: While control bit 2 (stop) is 1, spi_cs_n is high in every mode. In mode 11 with stop at 0, spi_cs_n stays low through and between window accesses.
- R7: SCK idles low. MOSI changes only while SCK is low, bits go out most significant first, and MISO is taken on the rising SCK edge.
- R8: Each SCK high phase and each SCK low phase inside a frame lasts max(divider code, 1) system clocks, so code 4 gives a period of eight clocks.
- R9: Between two frames in modes 00, 01 and 10, spi_cs_n stays high for at least (16 − gap code) clocks, and for twice that when configuration bit 1 is set.
- R10: bus_ready for a window access that shifts bytes stays low until the final SCK falling edge, and rises with that edge. Register accesses and ignored window writes are ready in the cycle they are presented.
- R11: With bus_win low, bus_addr[2] selects the register. 0 is configuration (bit 0 write enable, bit 1 double gap) and 1 is control (bits 1:0 mode, 2 stop, 3 four-byte address, 7:4 gap code, 10:8 divider code). bus_be[0] gates bits 7:0 and bus_be[1] gates bits 10:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, held until bus_ready |
| bus_win | input | 1 | 1 selects the flash window, 0 the registers |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | WIN_AW | Window byte offset, or register select in bit 2 |
| bus_be | input | 4 | Byte lane enables |
| bus_wdata | input | 32 | Write data, lane 0 in bits 7:0 |
| bus_rdata | output | 32 | Read data |
| bus_ready | output | 1 | Access completes on the clock edge where this is high |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions take for granted that a requester keeps bus_req and every bus field stable until it sees bus_ready, and that it drops bus_req right after. They also assume the byte enables form a non-empty run starting at lane 0, and that MISO changes only away from a rising SCK. The bench drives all accesses through tasks that hold the request through the handshake and use only the enables 0001, 0011, 0111 and 1111. Its flash model moves MISO only on falling SCK edges, so each rising edge samples a settled bit.

// File: rtl/spi_flash_ctl.sv
module spi_flash_ctl #(
  parameter int WIN_AW = 24,
  parameter int DIV_W = 3,
  parameter logic [DIV_W-1:0] DIV_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_win,
  input  logic              bus_we,
  input  logic [WIN_AW-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ready,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int GAP_W = 6;
  localparam logic [7:0] OP_RD = 8'h03;
  localparam logic [7:0] OP_WR = 8'h02;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} st_t;
  st_t st;

  logic [1:0] mode;
  logic stop, addr4, wen, x2;
  logic [3:0] gapc;
  logic [DIV_W-1:0] divc, hc;
  logic [GAP_W-1:0] hi_cnt;
  logic [2:0] bitc;
  logic [3:0] bi;
  logic [7:0] txsr, rxb, txb;
  logic [31:0] rxw;

  wire user = (mode == 2'b11);
  wire go_spi = user | ~bus_we | ((mode == 2'b10) & wen);
  wire [3:0] alen = addr4 ? 4'd4 : 4'd3;
  wire [3:0] hdr = user ? 4'd0 : alen + 4'd1;
  wire [3:0] last = hdr + 4'($countones(bus_be)) - 4'd1;
  wire [DIV_W-1:0] half = (divc == '0) ? DIV_W'(1) : divc;
  wire [4:0] gbase = 5'd16 - {1'b0, gapc};
  wire [GAP_W-1:0] gap_need = x2 ? {gbase, 1'b0} : {1'b0, gbase};
  wire gap_ok = user | (hi_cnt >= gap_need);
  wire start = (st == S_IDLE) & bus_req & bus_win & go_spi & gap_ok;
  wire tick = (st == S_RUN) & (hc == half - DIV_W'(1));
  wire [3:0] idx = (st == S_IDLE) ? 4'd0 : bi + 4'd1;
  wire [31:0] addr32 = 32'(bus_addr);
  wire [1:0] ashift = 2'(alen - idx);
  wire [1:0] dlane = 2'(idx - hdr);
  wire [1:0] rlane = 2'(bi - hdr);
  wire reg_wr = bus_req & ~bus_win & bus_we;

  always_comb begin
    if (!user && idx == 4'd0) txb = bus_we ? OP_WR : OP_RD;
    else if (!user && idx <= alen) txb = addr32[{ashift, 3'b000} +: 8];
    else txb = bus_we ? bus_wdata[{dlane, 3'b000} +: 8] : 8'h00;
  end

  assign bus_ready = bus_req & (~bus_win | ~go_spi | (st == S_DONE));
  assign bus_rdata = bus_win ? rxw :
                     bus_addr[2] ? 32'({divc, gapc, addr4, stop, mode}) : {30'd0, x2, wen};
  assign spi_cs_n = stop | ~(user | (st == S_RUN));
  assign spi_mosi = txsr[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= 2'b00; stop <= 1'b0; addr4 <= 1'b0; gapc <= 4'd0; divc <= DIV_RST;
      wen <= 1'b0; x2 <= 1'b0;
    end else if (reg_wr) begin
      if (bus_addr[2]) begin
        if (bus_be[0]) {gapc, addr4, stop, mode} <= bus_wdata[7:0];
        if (bus_be[1]) divc <= bus_wdata[8 +: DIV_W];
      end else if (bus_be[0]) begin
        {x2, wen} <= bus_wdata[1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= '1;
    else if (!spi_cs_n) hi_cnt <= '0;
    else if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; hc <= '0; bitc <= '0; bi <= '0;
      txsr <= '0; rxb <= '0; rxw <= '0; spi_sck <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st <= S_RUN; hc <= '0; bitc <= '0; bi <= '0;
          txsr <= txb; rxw <= '0; spi_sck <= 1'b0;
        end
        S_RUN: begin
          if (!tick) hc <= hc + DIV_W'(1);
          else begin
            hc <= '0;
            if (!spi_sck) begin
              spi_sck <= 1'b1;
              rxb <= {rxb[6:0], spi_miso};
            end else begin
              spi_sck <= 1'b0;
              if (bitc == 3'd7) begin
                if (bi >= hdr) rxw[{rlane, 3'b000} +: 8] <= rxb;
                if (bi == last) st <= S_DONE;
                else begin
                  bi <= bi + 4'd1; bitc <= '0; txsr <= txb;
                end
              end else begin
                bitc <= bitc + 3'd1;
                txsr <= {txsr[6:0], 1'b0};
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_flash_ctl_chk.sv
module spi_flash_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic        bus_win,
  input logic        bus_we,
  input logic        reg_sel,
  input logic [3:0]  bus_be,
  input logic [31:0] bus_wdata,
  input logic        bus_ready,
  input logic        spi_sck,
  input logic        spi_cs_n,
  input logic        spi_mosi,
  input logic [1:0]  mode,
  input logic        stop
);
  AST_STOP_RAISES_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_win && bus_we && reg_sel && bus_be[0] && bus_wdata[2]) |=> spi_cs_n); // R6
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> !spi_sck); // R7
  AST_MOSI_HOLD_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck) |-> $stable(spi_mosi)); // R7
  AST_READY_AFTER_SCK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_win && bus_ready) |-> !spi_sck); // R10
  AST_FRAME_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(spi_sck) && mode != 2'b11 && !stop) |-> !spi_cs_n); // R2
endmodule

bind spi_flash_ctl spi_flash_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_win(bus_win), .bus_we(bus_we),
  .reg_sel(bus_addr[2]), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
  .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .mode(mode), .stop(stop)
);

// File: tb/tb_spi_flash_ctl.sv
`timescale 1ns/1ps
module tb_spi_flash_ctl;
  logic clk = 0, rst_n = 0;
  logic bus_req = 0, bus_win = 0, bus_we = 0;
  logic [23:0] bus_addr = 0;
  logic [3:0] bus_be = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic bus_ready, spi_sck, spi_cs_n, spi_mosi, spi_miso;

  spi_flash_ctl dut (.clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_win(bus_win),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  logic [7:0] cap [0:15];
  logic [7:0] exp_b [0:15];
  logic [7:0] resp [0:15];
  int cap_n = 0, cap_bits = 0, exp_n = 0, resp_n = 0, mbit = 0;
  logic [7:0] cap_byte = 0;
  logic psck = 0, pmosi = 0, pcs = 1, lo_valid = 0;
  int hi_run = 0, lo_run = 0, cs_run = 1000;
  logic [1:0] exp_mode = 0;
  logic exp_stop = 0, exp_a4 = 0, exp_wen = 0, exp_x2 = 0;
  logic [3:0] exp_gapc = 0;
  logic [2:0] exp_div = 4;

  assign spi_miso = (mbit < resp_n * 8) ? resp[mbit >> 3][7 - (mbit & 7)] : 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic int eh();
    return (exp_div == 0) ? 1 : int'(exp_div);
  endfunction

  function automatic int egap();
    return (16 - int'(exp_gapc)) * (exp_x2 ? 2 : 1);
  endfunction

  // flash model and per-clock reference comparison
  always @(negedge clk) begin
    if (!rst_n) begin
      psck = 0; pmosi = 0; pcs = 1;
    end else begin
      if (spi_sck && !psck) begin
        cap_byte = {cap_byte[6:0], spi_mosi};
        cap_bits++;
        if (cap_bits == 8) begin
          if (cap_n < 16) cap[cap_n] = cap_byte;
          cap_n++; cap_bits = 0;
        end
        if (lo_valid) chk(lo_run == eh(), "R8", "SCK low phase", lo_run, eh());
        hi_run = 1;
      end else if (!spi_sck && psck) begin
        chk(hi_run == eh(), "R8", "SCK high phase", hi_run, eh());
        mbit++; lo_valid = 1; lo_run = 1;
      end else if (spi_sck) hi_run++;
      else lo_run++;
      if (spi_mosi !== pmosi && spi_sck) chk(1'b0, "R7", "MOSI moved with SCK high", spi_mosi, pmosi);
      if (exp_stop) chk(spi_cs_n == 1, "R6", "cs_n with stop set", spi_cs_n, 1);
      else if (exp_mode == 2'b11) chk(spi_cs_n == 0, "R6", "cs_n in user mode", spi_cs_n, 0);
      else if (!bus_req) chk(spi_cs_n == 1, "R2", "cs_n outside frame", spi_cs_n, 1);
      if (spi_cs_n) cs_run++;
      else begin
        if (pcs && exp_mode != 2'b11) chk(cs_run >= egap(), "R9", "cs_n high gap", cs_run, egap());
        cs_run = 0;
      end
      psck = spi_sck; pmosi = spi_mosi; pcs = spi_cs_n;
    end
  end

  task automatic clr();
    exp_n = 0; resp_n = 0;
    for (int i = 0; i < 16; i++) resp[i] = 8'h00;
  endtask
  task automatic expb(input logic [7:0] b); exp_b[exp_n] = b; exp_n++; endtask
  task automatic respb(input logic [7:0] b); resp[resp_n] = b; resp_n++; endtask

  task automatic cmp_bytes(input string req);
    bit ok = (cap_n == exp_n);
    if (!ok) chk(0, req, "MOSI byte count", cap_n, exp_n);
    else begin
      for (int i = 0; i < exp_n; i++)
        if (ok && cap[i] !== exp_b[i]) begin
          ok = 0; chk(0, req, $sformatf("MOSI byte %0d", i), cap[i], exp_b[i]);
        end
      if (ok) chk(1, req, "MOSI bytes", 0, 0);
    end
  endtask

  task automatic reg_wr(input bit sel, input logic [3:0] be, input logic [31:0] wd);
    @(negedge clk); #1;
    bus_req = 1; bus_win = 0; bus_we = 1; bus_addr = sel ? 24'd4 : 24'd0; bus_be = be; bus_wdata = wd;
    #0.5 chk(bus_ready == 1, "R10", "register write ready", bus_ready, 1);
    @(posedge clk); #1;
    bus_req = 0;
    if (sel) begin
      if (be[0]) {exp_gapc, exp_a4, exp_stop, exp_mode} = wd[7:0];
      if (be[1]) exp_div = wd[10:8];
    end else if (be[0]) {exp_x2, exp_wen} = wd[1:0];
  endtask

  task automatic reg_rd(input bit sel, output logic [31:0] rd);
    @(negedge clk); #1;
    bus_req = 1; bus_win = 0; bus_we = 0; bus_addr = sel ? 24'd4 : 24'd0; bus_be = 4'hF;
    #0.5 chk(bus_ready == 1, "R10", "register read ready", bus_ready, 1);
    rd = bus_rdata;
    @(posedge clk); #1;
    bus_req = 0;
  endtask

  task automatic win_acc(input bit we, input logic [23:0] a, input logic [3:0] be,
                         input logic [31:0] wd, output logic [31:0] rd, output bit imm);
    int n = 0;
    @(negedge clk); #1;
    cap_n = 0; cap_bits = 0; mbit = 0; lo_valid = 0;
    bus_req = 1; bus_win = 1; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = wd;
    #0.5;
    while (!bus_ready && n < 3000) begin
      @(negedge clk); #1.5; n++;
    end
    imm = (n == 0);
    if (n >= 3000) chk(0, "R10", "ready timeout", n, 0);
    rd = bus_rdata;
    @(posedge clk); #1;
    bus_req = 0;
  endtask

  logic [31:0] rd;
  bit imm;

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "WD", "watchdog expired", 0, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(spi_cs_n == 1, "R1", "reset cs_n", spi_cs_n, 1);
    chk(spi_sck == 0 && spi_mosi == 0, "R1", "reset sck/mosi", {spi_sck, spi_mosi}, 0);
    reg_rd(1, rd); chk(rd == 32'h400, "R1", "reset control", rd, 32'h400);
    reg_rd(0, rd); chk(rd == 32'h0, "R1", "reset config", rd, 0);

    // R2: four-byte normal read
    clr(); expb(8'h03); expb(8'h12); expb(8'h34); expb(8'h56);
    repeat (4) expb(8'h00);
    repeat (4) respb(8'h00);
    respb(8'hDE); respb(8'hAD); respb(8'hBE); respb(8'hEF);
    win_acc(0, 24'h123456, 4'hF, 0, rd, imm);
    cmp_bytes("R2"); chk(rd == 32'hEFBEADDE, "R2", "read data", rd, 32'hEFBEADDE);
    chk(spi_sck == 0, "R10", "SCK low at ready", spi_sck, 0);

    // R2/R9: two-byte read right after, default gap
    clr(); expb(8'h03); expb(8'h00); expb(8'h00); expb(8'h10); expb(8'h00); expb(8'h00);
    repeat (4) respb(8'h00);
    respb(8'h5A); respb(8'hA5);
    win_acc(0, 24'h000010, 4'h3, 0, rd, imm);
    cmp_bytes("R2"); chk(rd == 32'h0000A55A, "R2", "two-byte read", rd, 32'h0000A55A);

    // R3: four-byte address mode
    reg_wr(1, 4'h3, 32'h408);
    clr(); expb(8'h03); expb(8'h00); expb(8'hAB); expb(8'hCD); expb(8'hEF); expb(8'h00);
    repeat (5) respb(8'h00);
    respb(8'h77);
    win_acc(0, 24'hABCDEF, 4'h1, 0, rd, imm);
    cmp_bytes("R3"); chk(rd == 32'h77, "R3", "one-byte read", rd, 32'h77);

    // R9: shorter gap, then doubled gap
    reg_wr(1, 4'h3, 32'h4C0);
    for (int k = 0; k < 2; k++) begin
      clr(); respb(8'h00);
      win_acc(0, 24'h000020, 4'h1, 0, rd, imm);
    end
    reg_wr(0, 4'h1, 32'h2);
    for (int k = 0; k < 2; k++) begin
      clr(); respb(8'h00);
      win_acc(0, 24'h000020, 4'h1, 0, rd, imm);
    end
    reg_wr(0, 4'h1, 32'h0);
    reg_wr(1, 4'h3, 32'h400);

    // R4: ignored writes
    clr();
    win_acc(1, 24'h000040, 4'hF, 32'h12345678, rd, imm);
    chk(imm, "R4", "mode 00 write ready at once", imm, 1);
    cmp_bytes("R4");
    reg_wr(1, 4'h3, 32'h402);
    win_acc(1, 24'h000040, 4'hF, 32'h12345678, rd, imm);
    chk(imm, "R10", "ignored write ready at once", imm, 1);
    cmp_bytes("R4");

    // R4: program frame
    reg_wr(0, 4'h1, 32'h1);
    clr(); expb(8'h02); expb(8'h00); expb(8'h01); expb(8'h00);
    expb(8'h11); expb(8'h22); expb(8'h33);
    win_acc(1, 24'h000100, 4'h7, 32'h00332211, rd, imm);
    cmp_bytes("R4");
    reg_wr(0, 4'h1, 32'h0);

    // R5/R6: user-mode command bracket
    reg_wr(1, 4'h3, 32'h407);
    reg_wr(1, 4'h3, 32'h403);
    clr(); expb(8'h9F);
    win_acc(1, 24'h0, 4'h1, 32'h9F, rd, imm);
    cmp_bytes("R5");
    clr(); expb(8'h00); expb(8'h00); expb(8'h00);
    respb(8'hC2); respb(8'h20); respb(8'h19);
    win_acc(0, 24'h0, 4'h7, 0, rd, imm);
    cmp_bytes("R5"); chk(rd == 32'h001920C2, "R5", "user read", rd, 32'h001920C2);
    clr(); expb(8'hA1); expb(8'hB2); expb(8'hC3); expb(8'hD4);
    win_acc(1, 24'h0, 4'hF, 32'hD4C3B2A1, rd, imm);
    cmp_bytes("R5");
    reg_wr(1, 4'h3, 32'h407);
    @(negedge clk); #1 chk(spi_cs_n == 1, "R6", "cs_n after stop", spi_cs_n, 1);
    clr(); expb(8'hAA);
    win_acc(1, 24'h0, 4'h1, 32'hAA, rd, imm);
    cmp_bytes("R6");
    reg_wr(1, 4'h3, 32'h400);

    // R8/R11: divider codes through upper byte lane only
    reg_wr(1, 4'h2, 32'h000002FF);
    reg_rd(1, rd); chk(rd == 32'h200, "R11", "lane-gated control write", rd, 32'h200);
    clr(); expb(8'h03); expb(8'h00); expb(8'h00); expb(8'h01); expb(8'h00);
    repeat (4) respb(8'h00);
    respb(8'h3C);
    win_acc(0, 24'h000001, 4'h1, 0, rd, imm);
    cmp_bytes("R8"); chk(rd == 32'h3C, "R7", "MSB-first capture", rd, 32'h3C);
    reg_wr(1, 4'h2, 32'h100);
    clr(); repeat (4) respb(8'h00);
    respb(8'h81);
    win_acc(0, 24'h000002, 4'h1, 0, rd, imm);
    chk(rd == 32'h81, "R8", "read at divider 1", rd, 32'h81);
    reg_wr(1, 4'h2, 32'h700);
    clr(); repeat (4) respb(8'h00);
    respb(8'h6E);
    win_acc(0, 24'h000003, 4'h1, 0, rd, imm);
    chk(rd == 32'h6E, "R8", "read at divider 7", rd, 32'h6E);
    reg_wr(0, 4'h1, 32'h3);
    reg_rd(0, rd); chk(rd == 32'h3, "R11", "config readback", rd, 32'h3);

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule